// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column addresses of a single SDRAM read or write burst. When a column command is presented, it captures the start column, the programmed burst length and the burst ordering. From the next cycle on it emits one column address per accepted beat, until the burst completes, a stop request cuts it short, or a newer column command replaces it.

Bursts of 4 and 8 beats stay inside the aligned block that holds the start column. That block is walked either by a wrapping up-count (sequential order) or by XOR with the beat index (interleaved order). A full-page burst steps through the whole 8-bit column space and only ends on a stop request. Interleaved order has no meaning for a full page. That combination is flagged as a configuration error and the burst runs in sequential order.

The address output is a valid/ready stream. A beat is consumed on a cycle where both `col_valid` and `col_ready` are high. While `col_valid` is high and `col_ready` is low, the address and last flag hold and the beat does not advance. Back-pressure never blocks a column command or a stop request, because those act on the very edge where they are sampled.

Top module: `burst_col_seq`

## Requirements
- R1: After reset `col_valid`, `col_last` and `cfg_err` are all low.
- R2: A column command (`cmd_valid` high at a rising edge) makes `col_valid` high from the next cycle, with `col_addr` equal to the captured start column.
- R3: With `cmd_ilv`=0 and `cmd_len` 2'b00 (4 beats) or 2'b01 (8 beats), beat k has low bits (start + k) mod BL. The upper column bits equal the start column's.
- R4: With `cmd_ilv`=1 and a length of 4 or 8, beat k has low log2(BL) bits equal to the start column's low bits XOR k. The upper bits are unchanged.
- R5: With `cmd_len[1]`=1 (full page), beat k is (start + k) mod 256 over all 8 bits, and `col_last` never rises.
- R6: For 4- and 8-beat bursts, `col_last` is high exactly on beat BL-1. Once that beat is accepted, `col_valid` is low on the next cycle unless a new command arrived.
- R7: A stop request (`stop_req` high at an edge) ends the burst, and `col_valid` is low on the next cycle. If a command arrives in the same cycle, the command wins and a new burst starts.
- R8: A command with `cmd_ilv`=1 and full-page length sets `cfg_err` from the next cycle until the next command, and its addresses follow the R5 sequential order.
- R9: A command that arrives during an active burst abandons that burst and restarts the sequence at beat 0 from the new start column.
- R10: While `col_valid` is high and `col_ready` is low (no command, no stop), `col_addr` and `col_last` hold and the beat index does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Column command strobe; starts a burst |
| cmd_col | input | 8 | Start column of the burst |
| cmd_len | input | 2 | Burst length: 00 = 4, 01 = 8, 1x = full page |
| cmd_ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| stop_req | input | 1 | Burst stop request |
| col_ready | input | 1 | Consumer accepts the current beat |
| col_valid | output | 1 | A column address is being offered |
| col_addr | output | 8 | Column address of the current beat |
| col_last | output | 1 | Current beat is the final one of a 4/8 burst |
| cfg_err | output | 1 | Last command asked for interleaved full page |

## Verification
Three events can share a single edge: a column command, a stop request, and acceptance of the last beat. The mixed random stimulus raises command and stop together with some probability, so all three meet many times. Directed cases force a command at the same edge as a stop, and another command on the final accepted beat. In both cases the expected result is that a fresh burst begins at beat 0 with the new start column. The alternative outcome, an idle output, is what would follow if the stop or the end of the burst had taken priority.

// File: rtl/burst_col_seq_pkg.sv
package burst_col_seq_pkg;
  // burst length field of a column command
  typedef enum logic [1:0] {
    LEN_4    = 2'b00,
    LEN_8    = 2'b01,
    LEN_PAGE = 2'b10,
    LEN_PG2  = 2'b11
  } burst_len_e;

  // burst parameters held for the life of one burst
  typedef struct packed {
    logic full;
    logic ilv;
    logic err;
  } burst_mode_t;
endpackage

// File: rtl/bcs_len_decode.sv
module bcs_len_decode #(
  parameter int COL_W = 8
) (
  input  logic [1:0]       len,
  input  logic             ilv_req,
  output logic [COL_W-1:0] mask,
  output burst_col_seq_pkg::burst_mode_t mode
);
  import burst_col_seq_pkg::*;
  localparam logic [COL_W-1:0] MASK4 = COL_W'(3);
  localparam logic [COL_W-1:0] MASK8 = COL_W'(7);
  localparam logic [COL_W-1:0] MASKP = {COL_W{1'b1}};

  always_comb begin
    mode.full = len[1];
    mode.err  = ilv_req & len[1];
    mode.ilv  = ilv_req & ~len[1];
    unique case (burst_len_e'(len))
      LEN_4:   mask = MASK4;
      LEN_8:   mask = MASK8;
      default: mask = MASKP;
    endcase
  end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] low_seq;
  logic [COL_W-1:0] low_ilv;

  always_comb begin
    low_seq = (base + beat) & mask;
    low_ilv = (base ^ beat) & mask;
    addr    = (base & ~mask) | (ilv ? low_ilv : low_seq);
  end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [1:0]       cmd_len,
  input  logic             cmd_ilv,
  input  logic             stop_req,
  input  logic             col_ready,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last,
  output logic             cfg_err
);
  import burst_col_seq_pkg::*;

  logic             busy_q;
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  burst_mode_t      mode_q;

  logic [COL_W-1:0] dec_mask;
  burst_mode_t      dec_mode;
  logic             last_w, take_w;

  bcs_len_decode #(.COL_W(COL_W)) u_dec (
    .len(cmd_len), .ilv_req(cmd_ilv), .mask(dec_mask), .mode(dec_mode)
  );

  bcs_addr_gen #(.COL_W(COL_W)) u_gen (
    .base(base_q), .beat(beat_q), .mask(mask_q), .ilv(mode_q.ilv), .addr(col_addr)
  );

  assign last_w    = busy_q & ~mode_q.full & (beat_q == mask_q);
  assign take_w    = busy_q & col_ready;
  assign col_valid = busy_q;
  assign col_last  = last_w;
  assign cfg_err   = mode_q.err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
      mode_q <= '0;
    end else if (cmd_valid) begin
      busy_q <= 1'b1;
      base_q <= cmd_col;
      beat_q <= '0;
      mask_q <= dec_mask;
      mode_q <= dec_mode;
    end else if (stop_req) begin
      busy_q <= 1'b0;
    end else if (take_w) begin
      if (last_w) busy_q <= 1'b0;
      else        beat_q <= beat_q + 1'b1;
    end
  end
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [COL_W-1:0] cmd_col,
  input logic [1:0]       cmd_len,
  input logic             cmd_ilv,
  input logic             stop_req,
  input logic             col_ready,
  input logic             col_valid,
  input logic [COL_W-1:0] col_addr,
  input logic             col_last,
  input logic             cfg_err
);
  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> col_valid && col_addr == $past(cmd_col));
  // R6
  last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);
  // R6
  end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && col_last && col_ready && !cmd_valid |=> !col_valid);
  // R7
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req && !cmd_valid |=> !col_valid);
  // R5
  page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_len[1] |=> !col_last);
  // R8
  cfg_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ilv && cmd_len[1] |=> cfg_err);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !col_ready && !cmd_valid && !stop_req
    |=> col_valid && $stable(col_addr) && $stable(col_last));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
  .cmd_len(cmd_len), .cmd_ilv(cmd_ilv), .stop_req(stop_req),
  .col_ready(col_ready), .col_valid(col_valid), .col_addr(col_addr),
  .col_last(col_last), .cfg_err(cfg_err)
);

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_col = '0;
  logic [1:0] cmd_len = '0;
  logic       cmd_ilv = 1'b0;
  logic       stop_req = 1'b0;
  logic       col_ready = 1'b0;
  logic       col_valid, col_last, cfg_err;
  logic [7:0] col_addr;

  int total = 0;
  int bad = 0;

  // reference state of the burst, from the requirements
  logic       m_busy = 1'b0;
  logic [7:0] m_base = '0, m_beat = '0;
  logic [1:0] m_len = '0;
  logic       m_ilv = 1'b0, m_err = 1'b0;

  always #5 clk = ~clk;

  burst_col_seq uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
    .cmd_len(cmd_len), .cmd_ilv(cmd_ilv), .stop_req(stop_req),
    .col_ready(col_ready), .col_valid(col_valid), .col_addr(col_addr),
    .col_last(col_last), .cfg_err(cfg_err)
  );

  function automatic int blen(input logic [1:0] l);
    return l[1] ? 256 : (l[0] ? 8 : 4);
  endfunction

  function automatic logic [7:0] exp_addr();
    int n = blen(m_len);
    int lo = m_base % n;
    int hi = m_base - lo;
    int k = m_beat;
    if (m_ilv) return 8'(hi + (lo ^ (k % n)));
    return 8'(hi + ((lo + k) % n));
  endfunction

  function automatic logic exp_last();
    return m_busy && !m_len[1] && (int'(m_beat) == blen(m_len) - 1);
  endfunction

  function automatic string auto_tag();
    if (m_len[1]) return m_err ? "R8" : "R5";
    return m_ilv ? "R4" : "R3";
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag);
    string t = (tag == "") ? auto_tag() : tag;
    chk(8'(col_valid), 8'(m_busy), t, "valid");
    chk(8'(col_last), 8'(exp_last()), (m_busy && !m_len[1]) ? "R6" : t, "last");
    chk(8'(cfg_err), 8'(m_err), "R8", "cfg_err");
    if (m_busy) chk(col_addr, exp_addr(), t, "addr");
  endtask

  task automatic model_edge(input logic s, input logic [7:0] c, input logic [1:0] l,
                            input logic i, input logic sp, input logic r);
    if (s) begin
      m_busy = 1'b1; m_base = c; m_beat = '0; m_len = l;
      m_ilv = i && !l[1]; m_err = i && l[1];
    end else if (sp) begin
      m_busy = 1'b0;
    end else if (m_busy && r) begin
      if (exp_last()) m_busy = 1'b0;
      else m_beat = m_beat + 8'd1;
    end
  endtask

  task automatic step(input logic s, input logic [7:0] c, input logic [1:0] l,
                      input logic i, input logic sp, input logic r, input string tag);
    cmd_valid = s; cmd_col = c; cmd_len = l; cmd_ilv = i; stop_req = sp; col_ready = r;
    @(posedge clk);
    model_edge(s, c, l, i, sp, r);
    @(negedge clk);
    check_all(tag);
  endtask

  task automatic idle(input logic r, input string tag);
    step(1'b0, 8'h00, 2'b00, 1'b0, 1'b0, r, tag);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(8'(col_valid), 8'd0, "R1", "valid");
    chk(8'(col_last), 8'd0, "R1", "last");
    chk(8'(cfg_err), 8'd0, "R1", "cfg_err");

    // R2 / R3: 4-beat sequential from 0x35 wraps to 0x34
    step(1, 8'h35, 2'b00, 0, 0, 1, "R2");
    chk(col_addr, 8'h35, "R2", "first addr");
    idle(1, "R3"); idle(1, "R3"); idle(1, "R3");
    chk(col_addr, 8'h34, "R3", "wrap addr");
    chk(8'(col_last), 8'd1, "R6", "last beat4");
    idle(1, "R6");
    chk(8'(col_valid), 8'd0, "R6", "end after last");

    // R4: 8-beat interleave from 0x5B
    step(1, 8'h5B, 2'b01, 1, 0, 1, "R4");
    idle(1, "R4"); idle(1, "R4"); idle(1, "R4");
    chk(col_addr, 8'h58, "R4", "xor beat3");
    idle(1, "R4");
    chk(col_addr, 8'h5F, "R4", "xor beat4");
    repeat (4) idle(1, "R4");

    // R5: full page from 0xFE wraps, no last; R7 stop ends
    step(1, 8'hFE, 2'b10, 0, 0, 1, "R5");
    idle(1, "R5"); idle(1, "R5");
    chk(col_addr, 8'h00, "R5", "page wrap");
    repeat (300) idle(1, "R5");
    step(0, 8'h00, 2'b00, 0, 1, 1, "R7");
    chk(8'(col_valid), 8'd0, "R7", "stopped");

    // R8: interleave + full page falls back to sequential with error
    step(1, 8'h12, 2'b11, 1, 0, 1, "R8");
    idle(1, "R8");
    chk(col_addr, 8'h13, "R8", "seq fallback");
    chk(8'(cfg_err), 8'd1, "R8", "err flag");

    // R10: back-pressure holds
    step(1, 8'h40, 2'b01, 0, 0, 1, "R10");
    idle(1, "R10");
    idle(0, "R10"); idle(0, "R10"); idle(0, "R10");
    chk(col_addr, 8'h41, "R10", "held addr");
    chk(8'(cfg_err), 8'd0, "R8", "err cleared");

    // R9: new command mid-burst restarts
    step(1, 8'hA6, 2'b00, 1, 0, 1, "R9");
    chk(col_addr, 8'hA6, "R9", "restart addr");
    idle(1, "R9");
    chk(col_addr, 8'hA7, "R9", "restart beat1");

    // R7: command and stop together, command wins
    step(1, 8'h07, 2'b00, 0, 1, 1, "R7");
    chk(8'(col_valid), 8'd1, "R7", "cmd beats stop");
    chk(col_addr, 8'h07, "R7", "cmd beats stop addr");
    idle(1, "R3"); idle(1, "R3"); idle(1, "R3");
    // command on the accepted last beat
    step(1, 8'hC3, 2'b01, 0, 0, 1, "R9");
    chk(col_addr, 8'hC3, "R9", "cmd on last beat");

    // constrained random mix
    for (int n = 0; n < 6000; n++) begin
      logic s  = ($urandom % 100) < 12;
      logic sp = ($urandom % 100) < 4;
      logic r  = ($urandom % 100) < 75;
      logic i  = $urandom % 2;
      logic [1:0] l = 2'($urandom % 4);
      logic [7:0] c = 8'($urandom);
      step(s, c, l, i, sp, r, "");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule